// File: doc/BRIEF.md
# I2C Controller Control Register Unit

This block holds the 16-bit control word of an I2C controller and turns it into commands for a separate bit-level bus engine. A CPU-side port writes the whole word in one cycle. The current value is always visible on a read-back bus. Setting the START or STOP field sends a one-cycle request pulse to the engine. The field then stays readable as 1 until the engine reports completion or a timeout strobe arrives. Setting the abort field sends a request pulse of its own and holds until the engine reports that its reset has finished. Several write-protection rules depend on the bus-busy input and on the abort field.

Two small state machines carry the behaviour.

The command machine has three states:
- CMD_IDLE goes to CMD_START on a write with START = 1. Otherwise it goes to CMD_STOP on a write with STOP = 1.
- CMD_START goes back to CMD_IDLE on the start-done strobe or on the timeout strobe.
- CMD_STOP goes back to CMD_IDLE on the stop-done strobe or on the timeout strobe.
- From any state, the machine is forced to CMD_IDLE when the next value of the master or enable field is 0.

The abort machine has two states:
- ABT_OFF goes to ABT_ON on a write with bit 15 = 1.
- ABT_ON goes back to ABT_OFF on the reset-done strobe.
- From either state, the machine is forced to ABT_OFF when the next enable value is 0.

A timeout that hits a pending command sets a sticky timeout flag. The CPU interrupt line is the OR of four external source flags, each gated by its own enable, together with the timeout flag gated by its enable.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, rd_data is 0 and start_req, stop_req, abort_req, tmo_flag and irq are all 0.
- R2: The rd_data layout is: bit 15 abort, bit 9 stretch enable, bit 8 general-call enable, bit 7 STOP, bit 6 START, bit 5 ACK, bit 4 stretch select, bit 2 mode, bit 1 master, bit 0 enable. Bits 14:10 and bit 3 always read 0. Stretch enable, general-call enable and stretch select take the written value on every write.
- R3: A write that moves START (bit 6) or STOP (bit 7) from 0 to 1 makes the matching request output high for exactly the next cycle, the same cycle in which the field first reads 1. Writing the field again while it is pending gives no new pulse.
- R4: start_done clears a pending START and stop_done clears a pending STOP, visible in the next cycle. If a write that sets the same field arrives in the same cycle, the clear wins.
- R5: START and STOP are never 1 together. A STOP write while START is pending is ignored. A write with both bits set from idle sets only START. A START write while STOP is pending is ignored.
- R6: START and STOP are forced to 0 whenever the master bit (bit 1) or the enable bit (bit 0) is 0, including when the same write clears master or enable.
- R7: While bus_busy is 1, writes leave the mode and master bits unchanged. The enable bit is also left unchanged unless the abort bit is 1 at the time of the write.
- R8: A write with bit 15 = 1 sets the abort bit, and abort_req pulses high for the one cycle in which it first reads 1. The abort bit is cleared only by reset_done or by the enable bit being 0, and it cannot be set while enable is 0. While the abort bit is 1, writes leave ACK (bit 5) unchanged.
- R9: A timeout strobe while START or STOP is pending clears that field and sets tmo_flag in the next cycle. A timeout with nothing pending has no effect. tmo_clr clears tmo_flag, but a new timeout hit in the same cycle keeps it set.
- R10: irq equals the OR over i of (src_flags[i] AND src_ie[i]), ORed with (tmo_flag AND tmo_ie). Source index 0 is START-detected, 1 is transmit-complete, 2 is receive-ready and 3 is clock-stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| bus_busy | input | 1 | Bus is busy (from the bit engine) |
| start_done | input | 1 | Engine has generated the START |
| stop_done | input | 1 | Engine has generated the STOP |
| reset_done | input | 1 | Engine has finished its abort/reset |
| timeout | input | 1 | Timeout strobe from the external timer |
| tmo_clr | input | 1 | Clears the timeout flag |
| src_flags | input | 4 | Interrupt source flags |
| src_ie | input | 4 | Per-source interrupt enables |
| tmo_ie | input | 1 | Timeout interrupt enable |
| rd_data | output | 16 | Current control word |
| start_req | output | 1 | One-cycle START request to the engine |
| stop_req | output | 1 | One-cycle STOP request to the engine |
| abort_req | output | 1 | One-cycle abort request to the engine |
| tmo_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | CPU interrupt |

## Verification
The bench targets these corner cases:
- A done strobe that lands in the same cycle as a write setting the same command. A design that lets the write win would leave the command stuck pending.
- STOP written while START is pending, and both written at once. A wrong design would show both fields set or would send a second request.
- A master-clear or enable-clear that must kill a pending command. Missing this leaves requests running in slave mode.
- A write to enable under bus_busy while abort is set, which must go through. A write to ACK during abort, which must not.
- A timeout that must clear the command and raise the flag, plus one that arrives with nothing pending and must not.
- Long random runs that mix all strobes and check every output against a bench model.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    localparam int REG_W  = 16;
    localparam int NSRC   = 4;

    localparam int B_EN     = 0;
    localparam int B_MST    = 1;
    localparam int B_MODE   = 2;
    localparam int B_STRS   = 4;
    localparam int B_ACK    = 5;
    localparam int B_START  = 6;
    localparam int B_STOP   = 7;
    localparam int B_GCEN   = 8;
    localparam int B_STREN  = 9;
    localparam int B_ABORT  = 15;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_START = 2'd1,
        CMD_STOP  = 2'd2
    } cmd_state_e;

    typedef enum logic {
        ABT_OFF = 1'b0,
        ABT_ON  = 1'b1
    } abt_state_e;

    typedef struct packed {
        logic stren;
        logic gcen;
        logic ack;
        logic strs;
        logic mode;
        logic mst;
        logic en;
    } ctl_cfg_t;

endpackage

// File: rtl/i2c_ctl_cfg.sv
module i2c_ctl_cfg
    import i2c_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         bus_busy,
    input  logic         reset_done,
    output ctl_cfg_t     cfg_q,
    output logic         en_nx,
    output logic         mst_nx,
    output logic         abort_on,
    output logic         abort_pulse
);

    ctl_cfg_t   cfg_d;
    abt_state_e abt_q, abt_d;
    logic       abort_pulse_q;
    logic       unused_bits;

    assign unused_bits = ^{wr_data[14:10], wr_data[3]};

    // Configuration fields with their bus-state write protection.
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.stren = wr_data[B_STREN];
            cfg_d.gcen  = wr_data[B_GCEN];
            cfg_d.strs  = wr_data[B_STRS];
            if (abt_q == ABT_OFF) begin
                cfg_d.ack = wr_data[B_ACK];
            end
            if (!bus_busy) begin
                cfg_d.mode = wr_data[B_MODE];
                cfg_d.mst  = wr_data[B_MST];
            end
            if (!bus_busy || abt_q == ABT_ON) begin
                cfg_d.en = wr_data[B_EN];
            end
        end
    end

    assign en_nx  = cfg_d.en;
    assign mst_nx = cfg_d.mst;

    // Abort state machine: next state.
    always_comb begin
        abt_d = abt_q;
        unique case (abt_q)
            ABT_OFF: if (wr_en && wr_data[B_ABORT]) abt_d = ABT_ON;
            ABT_ON:  if (reset_done)                abt_d = ABT_OFF;
            default: abt_d = ABT_OFF;
        endcase
        if (reset_done || !cfg_d.en) begin
            abt_d = ABT_OFF;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abt_q <= ABT_OFF;
            cfg_q <= '0;
        end else begin
            abt_q <= abt_d;
            cfg_q <= cfg_d;
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            abort_pulse_q <= 1'b0;
        end else begin
            abort_pulse_q <= (abt_d == ABT_ON) && (abt_q == ABT_OFF);
        end
    end

    assign abort_on    = (abt_q == ABT_ON);
    assign abort_pulse = abort_pulse_q;

    a_r7_busy_lock_mode: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> ($stable(cfg_q.mode) && $stable(cfg_q.mst)));

    a_r7_busy_lock_en: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !abort_on) |=> $stable(cfg_q.en));

    a_r8_ack_lock: assert property (@(posedge clk) disable iff (!rst_n)
        abort_on |=> $stable(cfg_q.ack));

    a_r8_abort_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        abort_on |-> cfg_q.en);

    a_r8_reset_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |=> !abort_on);

endmodule

// File: rtl/i2c_ctl_cmd.sv
module i2c_ctl_cmd
    import i2c_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_start,
    input  logic wr_stop,
    input  logic allow,
    input  logic start_done,
    input  logic stop_done,
    input  logic timeout,
    output logic start_bit,
    output logic stop_bit,
    output logic start_req,
    output logic stop_req,
    output logic tmo_hit
);

    cmd_state_e state_q, state_d;
    logic       start_req_q, stop_req_q;

    // Command state machine: next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (wr_en && wr_start)     state_d = CMD_START;
                else if (wr_en && wr_stop) state_d = CMD_STOP;
            end
            CMD_START: if (start_done || timeout) state_d = CMD_IDLE;
            CMD_STOP:  if (stop_done  || timeout) state_d = CMD_IDLE;
            default:   state_d = CMD_IDLE;
        endcase
        if (!allow) begin
            state_d = CMD_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_req_q <= 1'b0;
            stop_req_q  <= 1'b0;
        end else begin
            start_req_q <= (state_d == CMD_START) && (state_q != CMD_START);
            stop_req_q  <= (state_d == CMD_STOP)  && (state_q != CMD_STOP);
        end
    end

    assign start_bit = (state_q == CMD_START);
    assign stop_bit  = (state_q == CMD_STOP);
    assign start_req = start_req_q;
    assign stop_req  = stop_req_q;
    assign tmo_hit   = timeout && (state_q != CMD_IDLE);

    a_r5_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_bit && stop_bit));

    a_r3_start_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> !start_req);

    a_r3_stop_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !stop_req);

    a_r4_start_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_bit && start_done) |=> !start_bit);

    a_r4_stop_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_bit && stop_done) |=> !stop_bit);

    a_r9_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !(start_bit || stop_bit) || $past(state_q == CMD_IDLE));

endmodule

// File: rtl/i2c_ctl_irq.sv
module i2c_ctl_irq
    import i2c_ctl_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tmo_hit,
    input  logic         tmo_clr,
    input  logic [N-1:0] src_flags,
    input  logic [N-1:0] src_ie,
    input  logic         tmo_ie,
    output logic         tmo_flag,
    output logic         irq
);

    logic         tflag_q;
    logic [N-1:0] gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tflag_q <= 1'b0;
        else if (tmo_hit) tflag_q <= 1'b1;
        else if (tmo_clr) tflag_q <= 1'b0;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        assign gated[i] = src_flags[i] & src_ie[i];
    end

    assign tmo_flag = tflag_q;
    assign irq      = (|gated) | (tflag_q & tmo_ie);

    a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> tmo_flag);

    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_clr && !tmo_hit) |=> !tmo_flag);

    a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ie == '0 && !tmo_ie) |-> !irq);

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
    import i2c_ctl_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         bus_busy,
    input  logic         start_done,
    input  logic         stop_done,
    input  logic         reset_done,
    input  logic         timeout,
    input  logic         tmo_clr,
    input  logic [N-1:0] src_flags,
    input  logic [N-1:0] src_ie,
    input  logic         tmo_ie,
    output logic [W-1:0] rd_data,
    output logic         start_req,
    output logic         stop_req,
    output logic         abort_req,
    output logic         tmo_flag,
    output logic         irq
);

    ctl_cfg_t cfg_q;
    logic     en_nx, mst_nx, abort_on;
    logic     start_bit, stop_bit, tmo_hit;

    i2c_ctl_cfg #(.W(W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .bus_busy    (bus_busy),
        .reset_done  (reset_done),
        .cfg_q       (cfg_q),
        .en_nx       (en_nx),
        .mst_nx      (mst_nx),
        .abort_on    (abort_on),
        .abort_pulse (abort_req)
    );

    i2c_ctl_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_start   (wr_data[B_START]),
        .wr_stop    (wr_data[B_STOP]),
        .allow      (en_nx && mst_nx),
        .start_done (start_done),
        .stop_done  (stop_done),
        .timeout    (timeout),
        .start_bit  (start_bit),
        .stop_bit   (stop_bit),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .tmo_hit    (tmo_hit)
    );

    i2c_ctl_irq #(.N(N)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_hit   (tmo_hit),
        .tmo_clr   (tmo_clr),
        .src_flags (src_flags),
        .src_ie    (src_ie),
        .tmo_ie    (tmo_ie),
        .tmo_flag  (tmo_flag),
        .irq       (irq)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[B_ABORT] = abort_on;
        rd_data[B_STREN] = cfg_q.stren;
        rd_data[B_GCEN]  = cfg_q.gcen;
        rd_data[B_STOP]  = stop_bit;
        rd_data[B_START] = start_bit;
        rd_data[B_ACK]   = cfg_q.ack;
        rd_data[B_STRS]  = cfg_q.strs;
        rd_data[B_MODE]  = cfg_q.mode;
        rd_data[B_MST]   = cfg_q.mst;
        rd_data[B_EN]    = cfg_q.en;
    end

    a_r6_cmd_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_START] || rd_data[B_STOP]) |-> (rd_data[B_MST] && rd_data[B_EN]));

    a_r3_req_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> rd_data[B_START]);

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[14:10] == 5'd0) && !rd_data[3]);

endmodule

// File: tb/tb_i2c_ctl_regs.sv
module tb_i2c_ctl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NRAND      = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, bus_busy, start_done, stop_done, reset_done;
    logic        timeout, tmo_clr, tmo_ie;
    logic [15:0] wr_data;
    logic [3:0]  src_flags, src_ie;
    logic [15:0] rd_data;
    logic        start_req, stop_req, abort_req, tmo_flag, irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Bench model of the register state.
    logic m_en, m_mst, m_mode, m_strs, m_ack, m_gcen, m_stren, m_abort;
    logic m_start, m_stop, m_sreq, m_preq, m_areq, m_tflag;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bus_busy(bus_busy), .start_done(start_done), .stop_done(stop_done),
        .reset_done(reset_done), .timeout(timeout), .tmo_clr(tmo_clr),
        .src_flags(src_flags), .src_ie(src_ie), .tmo_ie(tmo_ie),
        .rd_data(rd_data), .start_req(start_req), .stop_req(stop_req),
        .abort_req(abort_req), .tmo_flag(tmo_flag), .irq(irq)
    );

    function automatic logic [15:0] m_rd();
        return {m_abort, 5'b0, m_stren, m_gcen, m_stop, m_start, m_ack,
                m_strs, 1'b0, m_mode, m_mst, m_en};
    endfunction

    function automatic logic m_irq();
        return (|(src_flags & src_ie)) | (m_tflag & tmo_ie);
    endfunction

    task automatic model_reset();
        {m_en, m_mst, m_mode, m_strs, m_ack, m_gcen, m_stren, m_abort} = '0;
        {m_start, m_stop, m_sreq, m_preq, m_areq, m_tflag} = '0;
    endtask

    // Next model state from the requirements, using the inputs now applied.
    task automatic model_step();
        logic en_n, mst_n, ab_n, st_n, sp_n, pend;
        en_n  = (wr_en && (!bus_busy || m_abort)) ? wr_data[0] : m_en;
        mst_n = (wr_en && !bus_busy) ? wr_data[1] : m_mst;
        ab_n  = en_n && !reset_done && (m_abort || (wr_en && wr_data[15]));
        st_n = m_start;
        sp_n = m_stop;
        if (m_start) begin
            if (start_done || timeout) st_n = 1'b0;
        end else if (m_stop) begin
            if (stop_done || timeout) sp_n = 1'b0;
        end else if (wr_en && wr_data[6]) begin
            st_n = 1'b1;
        end else if (wr_en && wr_data[7]) begin
            sp_n = 1'b1;
        end
        if (!(en_n && mst_n)) begin
            st_n = 1'b0;
            sp_n = 1'b0;
        end
        pend = m_start || m_stop;
        if (wr_en && !m_abort) m_ack = wr_data[5];
        if (wr_en && !bus_busy) m_mode = wr_data[2];
        if (wr_en) begin
            m_strs  = wr_data[4];
            m_gcen  = wr_data[8];
            m_stren = wr_data[9];
        end
        m_sreq  = st_n && !m_start;
        m_preq  = sp_n && !m_stop;
        m_areq  = ab_n && !m_abort;
        m_tflag = (timeout && pend) || (m_tflag && !tmo_clr);
        m_en    = en_n;
        m_mst   = mst_n;
        m_abort = ab_n;
        m_start = st_n;
        m_stop  = sp_n;
    endtask

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        chk({"R2 readback ", ctx}, rd_data, m_rd());
        chk({"R5 start/stop bits ", ctx}, {14'd0, rd_data[7:6]}, {14'd0, m_stop, m_start});
        chk({"R3 request pulses ", ctx}, {13'd0, start_req, stop_req, abort_req},
            {13'd0, m_sreq, m_preq, m_areq});
        chk({"R8 abort bit ", ctx}, {15'd0, rd_data[15]}, {15'd0, m_abort});
        chk({"R9 timeout flag ", ctx}, {15'd0, tmo_flag}, {15'd0, m_tflag});
        chk({"R10 irq ", ctx}, {15'd0, irq}, {15'd0, m_irq()});
    endtask

    task automatic quiet();
        wr_en = 1'b0; wr_data = '0; bus_busy = 1'b0; start_done = 1'b0;
        stop_done = 1'b0; reset_done = 1'b0; timeout = 1'b0; tmo_clr = 1'b0;
    endtask

    // Called at a falling edge with inputs set; checks after the next rising edge.
    task automatic tick(string ctx);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(ctx);
        quiet();
    endtask

    task automatic wr(logic [15:0] d, logic busy, string ctx);
        wr_en = 1'b1; wr_data = d; bus_busy = busy;
        tick(ctx);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        quiet();
        src_flags = '0; src_ie = '0; tmo_ie = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 after reset");
        chk("R1 reset word", rd_data, 16'h0000);

        wr(16'h0003, 1'b0, "R7 enable and master");
        wr(16'h0043, 1'b0, "R3 start request");
        tick("R3 single pulse");
        wr(16'h00C3, 1'b0, "R5 stop while start ignored");
        wr(16'h0043, 1'b0, "R3 rewrite start no pulse");
        start_done = 1'b1;
        wr(16'h0043, 1'b0, "R4 done beats write");
        chk("R4 start cleared", {15'd0, rd_data[6]}, 16'd0);
        wr(16'h00C3, 1'b0, "R5 both set start wins");
        start_done = 1'b1;
        tick("R4 start done");
        wr(16'h0083, 1'b0, "R5 stop request");
        wr(16'h0043, 1'b0, "R5 start while stop ignored");
        wr(16'h0081, 1'b0, "R6 master cleared kills stop");
        chk("R6 stop killed", {15'd0, rd_data[7]}, 16'd0);
        wr(16'h0080, 1'b0, "R5 stop in slave ignored");
        wr(16'h0003, 1'b0, "R7 master again");
        wr(16'h0316, 1'b1, "R7 busy lock");
        chk("R7 locked fields", {13'd0, rd_data[2:0]}, 16'h0003);
        wr(16'h8021, 1'b1, "R8 abort set");
        wr(16'h8000, 1'b1, "R8 en writable under abort");
        chk("R8 abort dropped with en", {15'd0, rd_data[15]}, 16'd0);
        wr(16'h8000, 1'b0, "R8 abort blocked when disabled");
        wr(16'h8003, 1'b0, "R8 abort again");
        wr(16'h0003, 1'b0, "R8 ack ignored during abort");
        reset_done = 1'b1;
        tick("R8 reset done clears abort");
        timeout = 1'b1;
        tick("R9 timeout idle no effect");
        wr(16'h0043, 1'b0, "R9 start before timeout");
        timeout = 1'b1;
        tick("R9 timeout clears start");
        tmo_ie = 1'b1;
        tick("R10 timeout irq");
        tmo_clr = 1'b1;
        tick("R9 flag cleared");
        src_flags = 4'b0100; src_ie = 4'b0100;
        tick("R10 receive source");
        src_ie = 4'b1011;
        tick("R10 masked source");

        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr_en      = r[0] | r[1];
            wr_data    = $urandom;
            if (r[4:2] != 3'd0) wr_data[1:0] = 2'b11;
            bus_busy   = (r[7:5] < 3'd2);
            start_done = (r[10:8] == 3'd0);
            stop_done  = (r[13:11] == 3'd0);
            reset_done = (r[16:14] == 3'd0);
            timeout    = (r[20:17] == 4'd0);
            tmo_clr    = (r[23:21] == 3'd0);
            tmo_ie     = r[24];
            src_flags  = r[28:25];
            src_ie     = $urandom;
            tick("random");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule